// File: doc/BRIEF.md
# Two-Phase Lookup Table Store

This block keeps a table of 1024 entries, each 35 bits wide, for a translation engine. An entry has four fields: a line enable bit, an 8-bit first valid block, an 8-bit last valid block and an 18-bit line offset. A CPU writes and reads the table through a 32-bit register-style port. A translation engine reads the table through a separate lookup port. One entry does not fit in one bus word, so software writes it in two steps. The low word goes into a staging register and does not change the table. The high word then writes the staged fields and the offset into the table as one 35-bit entry.

A single memory serves both sides, and the block decides which side uses it in each cycle. A high-word CPU write wins over a lookup. A lookup wins over a CPU read. The side that loses is held off through its ready signal. A low-word write never touches the memory, so it never conflicts with a lookup. Writes are accepted at any time, including while lookups are in flight.

The control state machine has three states. ST_IDLE means no read result is due. ST_LK_DATA means the memory output belongs to a lookup. ST_CPU_DATA means it belongs to a CPU read. The next state is decided every cycle as follows:
- Accepting a lookup goes to ST_LK_DATA.
- Granting a CPU read goes to ST_CPU_DATA.
- Any other cycle goes to ST_IDLE.

These transitions apply from every state.

Top module: `seg_lut_store`

## Requirements
- R1: A lookup with `lk_valid` and `lk_ready` both high in a cycle returns the fields of entry `lk_index` on `lk_enable`, `lk_first`, `lk_last` and `lk_offset`, with `lk_rvalid` high, in the following cycle.
- R2: A CPU write with address bit 2 at 0 (the low word) loads the staging register: enable from data bit 0, first block from bits 15:8, last block from bits 23:16. The table is left unchanged, and reads and lookups still return the old entry.
- R3: A CPU write with address bit 2 at 1 (the high word) stores data bits 17:0 as the offset, together with the staged fields, into the entry selected by address bits 12:3. A read or lookup in any later cycle returns the new entry.
- R4: A CPU write is never stalled: `cpu_ready` is high in every cycle where `cpu_req` and `cpu_we` are both high. `cpu_ready` is never high without `cpu_req`.
- R5: In a cycle with a high-word CPU write, `lk_ready` is low. A pending lookup is therefore delayed and produces no `lk_rvalid` in the next cycle.
- R6: A low-word CPU write does not block lookups: `lk_ready` stays high and a concurrent lookup completes as in R1.
- R7: A CPU read in a cycle with `lk_valid` high gets `cpu_ready` low, and the lookup is served instead.
- R8: A granted CPU read (`cpu_ready` high) raises `cpu_rvalid` in the next cycle. The low-word read returns the stored entry, not the staging register, with enable in bit 0, first block in 15:8, last block in 23:16 and zeros elsewhere. The high-word read returns the offset in bits 17:0 and zeros above.
- R9: `cpu_rdata` is all zeros in every cycle where `cpu_rvalid` is low.
- R10: The staging register keeps its value after a high-word write, so several high-word writes after one low-word write all store the same enable, first and last fields.
- R11: After reset, `cpu_rvalid` and `lk_rvalid` are low and the staging register is zero. A high-word write made before any low-word write stores enable 0, first 0 and last 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 13 | Byte address: bits 12:3 entry index, bit 2 high/low word |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | CPU access granted this cycle |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | 32 | CPU read data |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | 10 | Lookup entry index |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_enable | output | 1 | Entry line enable |
| lk_first | output | 8 | Entry first valid block |
| lk_last | output | 8 | Entry last valid block |
| lk_offset | output | 18 | Entry line offset |

## Verification
Both ready signals are combinational from the request inputs. The bench samples them 1 ns after driving inputs on the falling edge, inside the same cycle. Read results from the lookup port and from CPU reads pass through one memory register, so they are sampled 1 ns after the next rising edge, and only there. A high-word write takes effect at the edge where it is granted, so the check that follows it reads the entry back in a later cycle. Every cycle that should return no CPU read result also confirms that `cpu_rvalid` and `cpu_rdata` are zero.

// File: rtl/seglut_pkg.sv
package seglut_pkg;

    localparam int unsigned BLK_W = 8;
    localparam int unsigned OFF_W = 18;

    typedef struct packed {
        logic             en;
        logic [BLK_W-1:0] first;
        logic [BLK_W-1:0] last;
    } lut_head_t;

    typedef struct packed {
        logic             en;
        logic [BLK_W-1:0] first;
        logic [BLK_W-1:0] last;
        logic [OFF_W-1:0] off;
    } lut_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CPU_DATA = 2'd1,
        ST_LK_DATA  = 2'd2
    } owner_e;

endpackage

// File: rtl/seglut_stage.sv
module seglut_stage
    import seglut_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             in_en,
    input  logic [BLK_W-1:0] in_first,
    input  logic [BLK_W-1:0] in_last,
    output lut_head_t        head
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (load) begin
            head.en    <= in_en;
            head.first <= in_first;
            head.last  <= in_last;
        end
    end

endmodule

// File: rtl/seglut_ram.sv
module seglut_ram
    import seglut_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  lut_entry_t       wentry,
    output lut_entry_t       rentry
);

    lut_entry_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                cells[addr] <= wentry;
            end else begin
                rentry <= cells[addr];
            end
        end
    end

endmodule

// File: rtl/seglut_arbiter.sv
module seglut_arbiter
    import seglut_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic cpu_hi,
    input  logic lk_valid,
    output logic cpu_ready,
    output logic lk_ready,
    output logic lk_take,
    output logic rd_take,
    output logic hi_wr,
    output logic lo_wr,
    output logic rd_hi,
    output logic cpu_rvalid,
    output logic lk_rvalid
);

    owner_e state, state_nx;

    always_comb begin
        hi_wr     = cpu_req & cpu_we & cpu_hi;
        lo_wr     = cpu_req & cpu_we & ~cpu_hi;
        lk_ready  = ~hi_wr;
        lk_take   = lk_valid & lk_ready;
        rd_take   = cpu_req & ~cpu_we & ~lk_valid;
        cpu_ready = (cpu_req & cpu_we) | rd_take;
        if (lk_take) begin
            state_nx = ST_LK_DATA;
        end else if (rd_take) begin
            state_nx = ST_CPU_DATA;
        end else begin
            state_nx = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rd_hi <= 1'b0;
        end else begin
            state <= state_nx;
            if (rd_take) begin
                rd_hi <= cpu_hi;
            end
        end
    end

    always_comb begin
        cpu_rvalid = 1'b0;
        lk_rvalid  = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_CPU_DATA: cpu_rvalid = 1'b1;
            ST_LK_DATA:  lk_rvalid  = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/seg_lut_store.sv
module seg_lut_store
    import seglut_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int unsigned BUS_W = 32,
    localparam int unsigned IDX_W  = $clog2(DEPTH),
    localparam int unsigned ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BUS_W-1:0]  cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [BUS_W-1:0]  cpu_rdata,
    input  logic              lk_valid,
    input  logic [IDX_W-1:0]  lk_index,
    output logic              lk_ready,
    output logic              lk_rvalid,
    output logic              lk_enable,
    output logic [BLK_W-1:0]  lk_first,
    output logic [BLK_W-1:0]  lk_last,
    output logic [OFF_W-1:0]  lk_offset
);

    localparam int unsigned FIRST_LSB = 8;
    localparam int unsigned LAST_LSB  = 16;

    logic       lk_take, rd_take, hi_wr, lo_wr, rd_hi;
    lut_head_t  head;
    lut_entry_t wentry, rentry;
    logic [IDX_W-1:0] mem_addr;
    logic       unused_bits;

    assign unused_bits = ^{cpu_addr[1:0], cpu_wdata[BUS_W-1:LAST_LSB+BLK_W],
                           cpu_wdata[FIRST_LSB-1:1]};

    seglut_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_hi     (cpu_addr[2]),
        .lk_valid   (lk_valid),
        .cpu_ready  (cpu_ready),
        .lk_ready   (lk_ready),
        .lk_take    (lk_take),
        .rd_take    (rd_take),
        .hi_wr      (hi_wr),
        .lo_wr      (lo_wr),
        .rd_hi      (rd_hi),
        .cpu_rvalid (cpu_rvalid),
        .lk_rvalid  (lk_rvalid)
    );

    seglut_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lo_wr),
        .in_en    (cpu_wdata[0]),
        .in_first (cpu_wdata[FIRST_LSB+BLK_W-1:FIRST_LSB]),
        .in_last  (cpu_wdata[LAST_LSB+BLK_W-1:LAST_LSB]),
        .head     (head)
    );

    always_comb begin
        mem_addr     = lk_take ? lk_index : cpu_addr[IDX_W+2:3];
        wentry.en    = head.en;
        wentry.first = head.first;
        wentry.last  = head.last;
        wentry.off   = cpu_wdata[OFF_W-1:0];
    end

    seglut_ram #(.DEPTH(DEPTH)) u_ram (
        .clk    (clk),
        .en     (lk_take | rd_take | hi_wr),
        .we     (hi_wr),
        .addr   (mem_addr),
        .wentry (wentry),
        .rentry (rentry)
    );

    always_comb begin
        lk_enable = rentry.en;
        lk_first  = rentry.first;
        lk_last   = rentry.last;
        lk_offset = rentry.off;
        cpu_rdata = '0;
        if (cpu_rvalid) begin
            if (rd_hi) begin
                cpu_rdata[OFF_W-1:0] = rentry.off;
            end else begin
                cpu_rdata[0] = rentry.en;
                cpu_rdata[FIRST_LSB+BLK_W-1:FIRST_LSB] = rentry.first;
                cpu_rdata[LAST_LSB+BLK_W-1:LAST_LSB]   = rentry.last;
            end
        end
    end

endmodule

// File: rtl/seglut_chk.sv
module seglut_chk #(
    parameter int unsigned BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_we,
    input logic             cpu_hi,
    input logic             cpu_ready,
    input logic             cpu_rvalid,
    input logic [BUS_W-1:0] cpu_rdata,
    input logic             lk_valid,
    input logic             lk_ready,
    input logic             lk_rvalid
);

    assert_lookup_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid && lk_ready |=> lk_rvalid);

    assert_write_never_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we |-> cpu_ready);

    assert_ready_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    assert_hi_write_blocks_lookup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && cpu_hi |-> !lk_ready);

    assert_lo_write_keeps_lookup_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && !cpu_hi |-> lk_ready);

    assert_read_yields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && lk_valid |-> !cpu_ready);

    assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && cpu_ready |=> cpu_rvalid);

    assert_rdata_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rvalid |-> cpu_rdata == '0);

    assert_single_owner_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_rvalid, lk_rvalid}));

endmodule

bind seg_lut_store seglut_chk #(.BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_hi     (cpu_addr[2]),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata),
    .lk_valid   (lk_valid),
    .lk_ready   (lk_ready),
    .lk_rvalid  (lk_rvalid)
);

// File: tb/test_seg_lut_store.sv
module test_seg_lut_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        lk_valid = 1'b0;
    logic [9:0]  lk_index = '0;
    logic        lk_ready, lk_rvalid, lk_enable;
    logic [7:0]  lk_first, lk_last;
    logic [17:0] lk_offset;

    int checks = 0;
    int errors = 0;

    bit        m_en    [1024];
    bit [7:0]  m_first [1024];
    bit [7:0]  m_last  [1024];
    bit [17:0] m_off   [1024];
    bit        s_en;
    bit [7:0]  s_first, s_last;
    bit [9:0]  pool [16];

    always #10 clk = ~clk;

    seg_lut_store i_seg_lut_store (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_low(input bit [9:0] i);
        return {8'h00, m_last[i], m_first[i], 7'h00, m_en[i]};
    endfunction

    function automatic logic [31:0] exp_high(input bit [9:0] i);
        return {14'h0000, m_off[i]};
    endfunction

    function automatic logic [34:0] lk_fields();
        return {lk_enable, lk_first, lk_last, lk_offset};
    endfunction

    function automatic logic [34:0] exp_fields(input bit [9:0] i);
        return {m_en[i], m_first[i], m_last[i], m_off[i]};
    endfunction

    task automatic idle();
        @(negedge clk);
        cpu_req = 0; cpu_we = 0; lk_valid = 0;
        @(posedge clk); #1;
    endtask

    task automatic cpu_write(input bit [9:0] i, input bit hi, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = {i, hi, 2'b00}; cpu_wdata = d; lk_valid = 0;
        #1 check("R4 write ready", cpu_ready, 1);
        @(posedge clk); #1;
        check("R9 rdata quiet", {cpu_rvalid, cpu_rdata}, 0);
        if (hi) begin
            m_en[i] = s_en; m_first[i] = s_first; m_last[i] = s_last; m_off[i] = d[17:0];
        end else begin
            s_en = d[0]; s_first = d[15:8]; s_last = d[23:16];
        end
    endtask

    task automatic cpu_read(input bit [9:0] i, input bit hi, input string req);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = {i, hi, 2'b00}; lk_valid = 0;
        #1 check({req, " read ready"}, cpu_ready, 1);
        @(posedge clk); #1;
        check({req, " read data"}, {cpu_rvalid, cpu_rdata}, {1'b1, hi ? exp_high(i) : exp_low(i)});
    endtask

    task automatic lookup(input bit [9:0] i, input string req);
        @(negedge clk);
        cpu_req = 0; lk_valid = 1; lk_index = i;
        #1 check({req, " lk_ready"}, lk_ready, 1);
        @(posedge clk); #1;
        check({req, " lookup data"}, {lk_rvalid, lk_fields()}, {1'b1, exp_fields(i)});
    endtask

    task automatic lookup_vs_read(input bit [9:0] li, input bit [9:0] ci, input bit hi);
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = {ci, hi, 2'b00}; lk_valid = 1; lk_index = li;
        #1 check("R7 read stalled", {cpu_ready, lk_ready}, 2'b01);
        @(posedge clk); #1;
        check("R7 lookup served", {lk_rvalid, lk_fields()}, {1'b1, exp_fields(li)});
        check("R9 no cpu data", {cpu_rvalid, cpu_rdata}, 0);
        cpu_read(ci, hi, "R7 retry");
    endtask

    task automatic lookup_vs_write(input bit [9:0] li, input bit [9:0] ci, input bit hi,
                                   input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1; cpu_we = 1; cpu_addr = {ci, hi, 2'b00}; cpu_wdata = d;
        lk_valid = 1; lk_index = li;
        #1 check(hi ? "R5 lk stalled" : "R6 lk kept", {cpu_ready, lk_ready}, {1'b1, ~hi});
        @(posedge clk); #1;
        if (hi) begin
            check("R5 no lookup result", lk_rvalid, 0);
            m_en[ci] = s_en; m_first[ci] = s_first; m_last[ci] = s_last; m_off[ci] = d[17:0];
            lookup(li, "R5 retry");
        end else begin
            check("R6 lookup result", {lk_rvalid, lk_fields()}, {1'b1, exp_fields(li)});
            s_en = d[0]; s_first = d[15:8]; s_last = d[23:16];
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1ce5));
        repeat (3) @(posedge clk);
        #1 check("R11 reset outputs", {cpu_rvalid, lk_rvalid, cpu_rdata}, 0);
        @(negedge clk) rst_n = 1;

        // R11: staging starts at zero
        cpu_write(10'd5, 1, 32'h0003_abcd);
        cpu_read(10'd5, 0, "R11");
        cpu_read(10'd5, 1, "R3");

        // boundary indices and pool fill
        pool[0] = 10'd0; pool[1] = 10'd1023;
        for (int k = 2; k < 16; k++) pool[k] = 10'($urandom % 1024);
        for (int k = 0; k < 16; k++) begin
            cpu_write(pool[k], 0, $urandom);
            cpu_write(pool[k], 1, $urandom);
        end
        for (int k = 0; k < 16; k++) begin
            cpu_read(pool[k], 0, "R8");
            cpu_read(pool[k], 1, "R8");
            lookup(pool[k], "R1");
        end

        // R2: low write alone leaves table unchanged
        cpu_write(10'd1023, 0, 32'hff5a_a501);
        cpu_read(10'd1023, 0, "R2");
        lookup(10'd1023, "R2");
        // R10: staged fields reused by two commits
        cpu_write(10'd1023, 1, 32'h0000_1111);
        cpu_write(10'd0, 1, 32'h0002_2222);
        cpu_read(10'd1023, 0, "R10");
        cpu_read(10'd0, 0, "R10");
        lookup(10'd0, "R3");

        // directed conflicts
        lookup_vs_read(10'd0, 10'd1023, 1);
        lookup_vs_write(10'd1023, 10'd1023, 1, 32'h0001_7777);
        lookup_vs_write(10'd0, 10'd0, 0, 32'h0012_3400);
        cpu_read(10'd0, 0, "R2");
        idle();
        check("R9 idle", {cpu_rvalid, cpu_rdata, lk_rvalid}, 0);

        for (int n = 0; n < 400; n++) begin
            bit [9:0] a = pool[$urandom % 16];
            bit [9:0] b = pool[$urandom % 16];
            case ($urandom % 7)
                0: cpu_write(a, 0, $urandom);
                1: cpu_write(a, 1, $urandom);
                2: cpu_read(a, 0, "R8");
                3: cpu_read(a, 1, "R8");
                4: lookup(a, "R1");
                5: lookup_vs_read(a, b, 1'($urandom));
                default: lookup_vs_write(a, b, 1'($urandom), $urandom);
            endcase
        end
        idle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule